// File: doc/BRIEF.md
# Externally Clocked Serial Result Reader

This block sends a stored conversion result out as a serial stream, timed by a data clock that the host supplies. The host asks for a read in one of two ways: it raises the read/convert line while chip select is already low, or it drops chip select while read/convert is already high. The block answers with a sync pulse that lasts one clock. The result bits follow, most significant bit first, one bit per clock.

Once the last result bit has gone out, the data line carries the serial tag input, delayed by as many clocks as the result has bits. Several readers can therefore be chained on one stream. A converter upstream delivers each finished result through a load strobe. A read returns the most recently loaded result, so a read issued while the next conversion is still running returns the previous one. A format input chooses between straight binary and two's complement on the wire.

Top module: `xclk_serial_reader`

## Requirements
- R1: A read command is registered at a clock edge only when chip select is low and read/convert is high at that edge, and, at the previous edge, either chip select was high or read/convert was low. Raising read/convert while chip select is high starts nothing.
- R2: `sync_o` is high for exactly the one clock period that follows the edge where a read command was registered. Otherwise it is low.
- R3: The W result bits appear on `data_o` one per clock, most significant first, in the W clock periods that follow the sync period.
- R4: With `fmt_straight` = 1 the bits go out as stored (straight binary). With `fmt_straight` = 0 the most significant bit is inverted (two's complement). The format is sampled at the command edge.
- R5: After the least significant result bit, and for as long as the read stays open, `data_o` equals the value `tag_in` had TAG_DLY clock edges earlier. TAG_DLY defaults to W, and `tag_in` counts as 0 during reset.
- R6: At any edge where chip select is high or read/convert is low, the read ends. In the next period `data_o` is 0 and `sync_o` is 0, and shifting does not resume without a new command.
- R7: A read returns the value captured by the latest `res_load` strobe at an edge before the command edge. A load at the same edge as the command is not seen by that read, but is seen by the next one.
- R8: While reset is active, and after it until a command, `sync_o` and `data_o` are 0.
- R9: A read that is ended and then reissued starts again from the sync pulse and the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External data clock. All state changes on its rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_cv | input | 1 | Read/convert line; high selects read |
| tag_in | input | 1 | Serial tag stream forwarded after the result |
| fmt_straight | input | 1 | 1 = straight binary, 0 = two's complement |
| res_word | input | W | Finished conversion result (straight binary) |
| res_load | input | 1 | Strobe that captures `res_word` as the stored result |
| sync_o | output | 1 | One-clock pulse that opens a read |
| data_o | output | 1 | Serial result bits, then the delayed tag |

## Verification
The bench targets both command edges and the look-alike that must not trigger: read/convert rising while chip select is high. A detector that ignored chip select would emit a stray sync pulse there. It also loads a result at the very edge of a command. A design that forwarded the new value would return the new result where the old one is due. Reads are broken off partway through the bits by each control line in turn. A design that kept shifting, or that resumed from the old position, shows up when the read is reissued. The tag phase is checked against a history of the tag input kept for every edge, which exposes an off-by-one delay or a tag that is switched in one clock too early.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

   typedef enum logic {
      FMT_TWOS     = 1'b0,
      FMT_STRAIGHT = 1'b1
   } rdx_fmt_e;

   localparam int RDX_MIN_W = 2;

endpackage

// File: rtl/rdx_cmd_detect.sv
module rdx_cmd_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_cv,
   output logic cmd_o,
   output logic open_o
);
   logic cs_n_q;
   logic rd_cv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_q  <= 1'b0;
         rd_cv_q <= 1'b1;
      end else begin
         cs_n_q  <= cs_n;
         rd_cv_q <= rd_cv;
      end
   end

   assign open_o = !cs_n && rd_cv;
   assign cmd_o  = open_o && (cs_n_q || !rd_cv_q);

   // R1
   no_back_to_back_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o |=> !cmd_o);

endmodule

// File: rtl/rdx_tag_delay.sv
module rdx_tag_delay #(
   parameter int DEPTH = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tag_in,
   output logic tag_o
);
   generate
      if (DEPTH < 0) begin : g_bad_depth
         $error("rdx_tag_delay: DEPTH must not be negative");
      end
      if (DEPTH == 0) begin : g_wire
         assign tag_o = tag_in;
      end else begin : g_line
         logic [DEPTH-1:0] stage;
         logic             primed;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage  <= '0;
               primed <= 1'b0;
            end else begin
               stage[0] <= tag_in;
               primed   <= 1'b1;
            end
         end

         for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[i] <= 1'b0;
               else        stage[i] <= stage[i-1];
            end
         end

         assign tag_o = stage[DEPTH-1];

         // R5
         first_stage_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (stage[0] == $past(tag_in)));
      end
   endgenerate

endmodule

// File: rtl/rdx_word_shifter.sv
module rdx_word_shifter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd,
   input  logic         open_rd,
   input  logic         fmt_straight,
   input  logic [W-1:0] res_word,
   input  logic         res_load,
   input  logic         tag_dly,
   output logic         sync_o,
   output logic         data_o
);
   import rdx_pkg::*;

   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  held;
   logic [W-1:0]  fmt_word;
   logic [W-1:0]  shreg;
   logic [CW-1:0] left;
   logic          active;
   logic          sync_q;
   logic          data_q;

   generate
      if (W < RDX_MIN_W) begin : g_bad_w
         $error("rdx_word_shifter: W too small");
      end
   endgenerate

   always_comb begin
      fmt_word = held;
      if (rdx_fmt_e'(fmt_straight) == FMT_TWOS)
         fmt_word[W-1] = ~held[W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held   <= '0;
         shreg  <= '0;
         left   <= '0;
         active <= 1'b0;
         sync_q <= 1'b0;
         data_q <= 1'b0;
      end else begin
         if (cmd) begin
            sync_q <= 1'b1;
            shreg  <= fmt_word;
            left   <= CW'(W);
            active <= 1'b1;
            data_q <= 1'b0;
         end else if (active && !open_rd) begin
            active <= 1'b0;
            sync_q <= 1'b0;
            data_q <= 1'b0;
            left   <= '0;
         end else if (active) begin
            sync_q <= 1'b0;
            if (left != '0) begin
               data_q <= shreg[W-1];
               shreg  <= {shreg[W-2:0], 1'b0};
               left   <= left - 1'b1;
            end else begin
               data_q <= tag_dly;
            end
         end else begin
            sync_q <= 1'b0;
            data_q <= 1'b0;
         end
         if (res_load) held <= res_word;
      end
   end

   assign sync_o = sync_q;
   assign data_o = data_q;

   // R3
   bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left <= CW'(W));

   // R2
   sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> !sync_o);

   // R2
   sync_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd |=> sync_o);

   // R6
   closed_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_rd && !cmd) |=> (!data_o && !sync_o));

endmodule

// File: rtl/xclk_serial_reader.sv
module xclk_serial_reader #(
   parameter int W       = 12,
   parameter int TAG_DLY = W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n,
   input  logic         rd_cv,
   input  logic         tag_in,
   input  logic         fmt_straight,
   input  logic [W-1:0] res_word,
   input  logic         res_load,
   output logic         sync_o,
   output logic         data_o
);
   logic cmd;
   logic open_rd;
   logic tag_dly;

   rdx_cmd_detect u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .rd_cv  (rd_cv),
      .cmd_o  (cmd),
      .open_o (open_rd)
   );

   rdx_tag_delay #(.DEPTH(TAG_DLY)) u_tag (
      .clk    (clk),
      .rst_n  (rst_n),
      .tag_in (tag_in),
      .tag_o  (tag_dly)
   );

   rdx_word_shifter #(.W(W)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd          (cmd),
      .open_rd      (open_rd),
      .fmt_straight (fmt_straight),
      .res_word     (res_word),
      .res_load     (res_load),
      .tag_dly      (tag_dly),
      .sync_o       (sync_o),
      .data_o       (data_o)
   );

   // R1
   cmd_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && rd_cv) |=> !sync_o);

endmodule

// File: tb/xclk_serial_reader_tb.sv
module xclk_serial_reader_tb;
   localparam int CLK_P = 10;
   localparam int W     = 12;
   localparam int DLY   = 12;
   localparam int LIMIT = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic rd_cv = 1'b1;
   logic tag_in = 1'b0;
   logic fmt_straight = 1'b1;
   logic [W-1:0] res_word = '0;
   logic res_load = 1'b0;
   logic sync_o;
   logic data_o;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   string scen = "R8";
   string phase = "R8";

   // behavioural reference state
   int m_held = 0, m_word = 0, m_left = 0;
   bit m_active = 0, m_sync = 0, m_data = 0;
   bit m_cs_prev = 0, m_rc_prev = 1;
   bit tag_q[$];

   xclk_serial_reader #(.W(W), .TAG_DLY(DLY)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cv(rd_cv), .tag_in(tag_in),
      .fmt_straight(fmt_straight), .res_word(res_word), .res_load(res_load),
      .sync_o(sync_o), .data_o(data_o));

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      bit cmd, dtag;
      if (!rst_n) begin
         m_held = 0; m_word = 0; m_left = 0; m_active = 0;
         m_sync = 0; m_data = 0; m_cs_prev = 0; m_rc_prev = 1;
         tag_q.push_back(1'b0);
         phase = "R8";
      end else begin
         dtag = (tag_q.size() >= DLY) ? tag_q[tag_q.size()-DLY] : 1'b0;
         cmd = !cs_n && rd_cv && (m_cs_prev || !m_rc_prev);
         if (cmd) begin
            m_sync = 1; m_data = 0; m_active = 1; m_left = W;
            m_word = fmt_straight ? m_held : (m_held ^ (1 << (W-1)));
            phase = "R2";
         end else if (m_active && (cs_n || !rd_cv)) begin
            m_active = 0; m_sync = 0; m_data = 0; m_left = 0;
            phase = "R6";
         end else if (m_active) begin
            m_sync = 0;
            if (m_left > 0) begin
               m_data = (m_word >> (m_left-1)) & 1;
               m_left--;
               phase = "R3 R4";
            end else begin
               m_data = dtag;
               phase = "R5";
            end
         end else begin
            m_sync = 0; m_data = 0;
            phase = "R1";
         end
         if (res_load) m_held = int'(res_word);
         m_cs_prev = cs_n; m_rc_prev = rd_cv;
         tag_q.push_back(tag_in);
      end
      if (tag_q.size() > 32) void'(tag_q.pop_front());
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (sync_o !== m_sync) begin
            fails++;
            $display("FAIL %s/%s sync_o actual=%b expected=%b", scen, phase, sync_o, m_sync);
         end
         checks++;
         if (data_o !== m_data) begin
            fails++;
            $display("FAIL %s/%s data_o actual=%b expected=%b", scen, phase, data_o, m_data);
         end
      end
   end

   // tag stream changes between edges
   initial forever begin
      @(negedge clk);
      tag_in = 1'($urandom % 2);
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load(input logic [W-1:0] v);
      @(negedge clk);
      res_word = v; res_load = 1'b1;
      @(negedge clk);
      res_load = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R8: idle after reset
      scen = "R8"; tick(3);

      // R1 R3 R5: chip select falls with read/convert high, straight binary
      scen = "R1"; fmt_straight = 1'b1;
      load(12'hA5C); tick(1);
      cs_n = 1'b0; tick(30);
      // R6: chip select rises ends the read
      scen = "R6"; cs_n = 1'b1; tick(4);

      // R4: two's complement, read/convert rising with chip select low
      scen = "R4"; fmt_straight = 1'b0;
      rd_cv = 1'b0; tick(2);
      cs_n = 1'b0; tick(2);
      rd_cv = 1'b1; tick(18);
      // R6: read/convert falls mid-stream
      scen = "R6"; cs_n = 1'b1; tick(2);
      cs_n = 1'b0; tick(6);
      rd_cv = 1'b0; tick(5);
      cs_n = 1'b1; tick(2);

      // R1: read/convert rises while chip select is high, nothing starts
      scen = "R1"; rd_cv = 1'b0; tick(2);
      rd_cv = 1'b1; tick(6);

      // R7: load at the same edge as the command is not seen
      scen = "R7"; fmt_straight = 1'b1;
      res_word = 12'h3F0; res_load = 1'b1; cs_n = 1'b0;
      tick(1); res_load = 1'b0; tick(15);
      cs_n = 1'b1; tick(2);
      cs_n = 1'b0; tick(16);
      cs_n = 1'b1; tick(2);

      // R9: break off and reissue
      scen = "R9"; load(12'h9C3);
      cs_n = 1'b0; tick(5);
      cs_n = 1'b1; tick(1);
      cs_n = 1'b0; tick(16);
      cs_n = 1'b1; tick(2);

      // R4: boundary words in two's complement
      scen = "R4"; fmt_straight = 1'b0;
      load(12'hFFF); cs_n = 1'b0; tick(15); cs_n = 1'b1; tick(2);
      load(12'h000); cs_n = 1'b0; tick(15); cs_n = 1'b1; tick(2);

      // R5: long tag tail
      scen = "R5"; fmt_straight = 1'b1; load(12'h5A5);
      cs_n = 1'b0; tick(60); cs_n = 1'b1; tick(3);

      finish_run();
   end

   initial begin
      for (int i = 0; i < LIMIT; i++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule